// File: doc/BRIEF.md
# Battery Overvoltage Fault Monitor

This block protects a single-cell charger when the battery rises about 5% above its regulation target. A digitized overvoltage comparator drives the protective outputs at once. The converter is shut off and the battery FET is forced fully on, so that the cell can bleed down through the system load. The fault reported to a status register is deglitched: it is latched only when the comparator stays high for a full dwell window of `DWELL_CYCLES` clock edges. The default of 1000 edges gives 1 ms at 1 MHz.

Once protection has started, it holds even if the comparator drops. It is released only by a release condition: the battery falls below the recharge comparator, high-impedance mode is set, or the chip-disable pin is high. While protection is held, an inhibit output blocks the charge controller from starting a new cycle.

The controller is a four-state machine:

- **ST_IDLE**: no protection held.
- **ST_TRIP**: protection held, comparator high, dwell counter running.
- **ST_HOLD**: protection held, comparator low, counter cleared.
- **ST_FAULT**: fault latched.

The transitions are named as follows:

- **arm** (IDLE→TRIP): first high sample, no release active.
- **dwell_done** (TRIP/HOLD/IDLE→FAULT): the Nth consecutive high sample.
- **drop** (TRIP→HOLD): comparator low.
- **retrip** (HOLD→TRIP): comparator high again, with the count restarting.
- **release** (any→IDLE): release condition sampled.

Release has priority over every other transition.

Top module: `bovp_monitor`

## Requirements
- R1: In the same cycle that `ovp_cmp` is high, `conv_off` and `fet_force_on` are high, with no clock edge in between.
- R2: `fault_flag` rises right after the clock edge at which `ovp_cmp` has been sampled high on `DWELL_CYCLES` consecutive edges, and not earlier.
- R3: A run of high samples shorter than `DWELL_CYCLES` that is broken by a low sample does not set the fault, and the next run must again be `DWELL_CYCLES` edges long.
- R4: Once protection has started, `conv_off`, `fet_force_on` and `chg_inhibit` stay high after `ovp_cmp` falls, until a release condition is sampled. A latched `fault_flag` likewise stays high.
- R5: Sampling `below_rch` high returns the block to idle. `fault_flag` and `chg_inhibit` are low after that edge, and `conv_off` then follows `ovp_cmp` only.
- R6: Sampling `hz_mode` or `chip_dis` high likewise returns the block to idle. While either is high, no fault is latched and protection is not held, although `conv_off` still follows `ovp_cmp` directly.
- R7: When a release condition and the final dwell sample occur at the same edge, the release wins and `fault_flag` stays low.
- R8: `chg_inhibit` is high from the edge after the first high comparator sample until release, including the whole time the fault is latched.
- R9: During and after reset, with `ovp_cmp` low, all four outputs are low.
- R10: After a release, a new overvoltage event is handled from a clean start: protection is immediate and the fault takes a full dwell window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ovp_cmp | input | 1 | Battery overvoltage comparator, high when over the limit |
| below_rch | input | 1 | High when the battery is below the recharge threshold |
| hz_mode | input | 1 | High-impedance mode control bit |
| chip_dis | input | 1 | Hardware chip-disable pin, active high |
| conv_off | output | 1 | Converter shutdown |
| fet_force_on | output | 1 | Forces the battery FET fully on |
| chg_inhibit | output | 1 | Blocks the start of a new charge cycle |
| fault_flag | output | 1 | Latched, deglitched overvoltage fault |

## Verification
The comparator is driven with three kinds of input:

- **A run held exactly one edge short of the dwell window, then completed.** This separates an off-by-one counter from a correct one.
- **A short run, a gap and a second short run whose sum exceeds the window.** This separates a counter that restarts from one that merely pauses.
- **Comparator drops after tripping, with no release.** This shows that protection is held by state rather than by the comparator.

Each of the three release sources is applied on its own, both to a latched fault and during a run. A release that coincides with the final dwell sample checks the priority of release over latching.

// File: rtl/bovp_pkg.sv
package bovp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRIP  = 2'd1,
        ST_HOLD  = 2'd2,
        ST_FAULT = 2'd3
    } bovp_state_e;

endpackage

// File: rtl/bovp_release.sv
module bovp_release (
    input  logic below_rch,
    input  logic hz_mode,
    input  logic chip_dis,
    output logic release_req
);

    // Any one source ends protection and clears a latched fault.
    always_comb begin
        release_req = below_rch | hz_mode | chip_dis;
    end

endmodule

// File: rtl/bovp_dwell_cnt.sv
module bovp_dwell_cnt #(
    parameter int DWELL_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);

    localparam int CW = (DWELL_CYCLES < 2) ? 1 : $clog2(DWELL_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(DWELL_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (en && (cnt_q != LAST)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Asserted while the sample being taken is the Nth consecutive one.
    always_comb begin
        done = en && (cnt_q == LAST);
    end

endmodule

// File: rtl/bovp_fsm.sv
module bovp_fsm
    import bovp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ovp_cmp,
    input  logic        release_req,
    input  logic        dwell_done,
    output logic        cnt_clr,
    output logic        conv_off,
    output logic        fet_force_on,
    output logic        chg_inhibit,
    output logic        fault_flag
);

    bovp_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (release_req)     state_d = ST_IDLE;
                else if (dwell_done) state_d = ST_FAULT;
                else if (ovp_cmp)    state_d = ST_TRIP;
            end
            ST_TRIP: begin
                if (release_req)     state_d = ST_IDLE;
                else if (!ovp_cmp)   state_d = ST_HOLD;
                else if (dwell_done) state_d = ST_FAULT;
            end
            ST_HOLD: begin
                if (release_req)     state_d = ST_IDLE;
                else if (dwell_done) state_d = ST_FAULT;
                else if (ovp_cmp)    state_d = ST_TRIP;
            end
            ST_FAULT: begin
                if (release_req)     state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        // The count restarts on every low sample and on any release.
        cnt_clr      = !ovp_cmp || release_req || (state_q == ST_FAULT);
        // The protective action takes the comparator directly.
        conv_off     = ovp_cmp || (state_q != ST_IDLE);
        fet_force_on = ovp_cmp || (state_q != ST_IDLE);
        chg_inhibit  = (state_q != ST_IDLE);
        fault_flag   = (state_q == ST_FAULT);
    end

endmodule

// File: rtl/bovp_monitor.sv
module bovp_monitor #(
    parameter int DWELL_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovp_cmp,
    input  logic below_rch,
    input  logic hz_mode,
    input  logic chip_dis,
    output logic conv_off,
    output logic fet_force_on,
    output logic chg_inhibit,
    output logic fault_flag
);

    logic release_req;
    logic cnt_clr;
    logic dwell_done;

    bovp_release u_release (
        .below_rch   (below_rch),
        .hz_mode     (hz_mode),
        .chip_dis    (chip_dis),
        .release_req (release_req)
    );

    bovp_dwell_cnt #(
        .DWELL_CYCLES (DWELL_CYCLES)
    ) u_dwell (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .en    (ovp_cmp),
        .done  (dwell_done)
    );

    bovp_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ovp_cmp      (ovp_cmp),
        .release_req  (release_req),
        .dwell_done   (dwell_done),
        .cnt_clr      (cnt_clr),
        .conv_off     (conv_off),
        .fet_force_on (fet_force_on),
        .chg_inhibit  (chg_inhibit),
        .fault_flag   (fault_flag)
    );

endmodule

// File: rtl/bovp_monitor_chk.sv
module bovp_monitor_chk #(
    parameter int DWELL_CYCLES = 1000
) (
    input logic clk,
    input logic rst_n,
    input logic ovp_cmp,
    input logic below_rch,
    input logic hz_mode,
    input logic chip_dis,
    input logic conv_off,
    input logic fet_force_on,
    input logic chg_inhibit,
    input logic fault_flag
);

    logic        rel;
    logic [31:0] run_q;

    assign rel = below_rch | hz_mode | chip_dis;

    // Length of the current run of high comparator samples.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!ovp_cmp) begin
            run_q <= '0;
        end else if (run_q != 32'hFFFF_FFFF) begin
            run_q <= run_q + 1'b1;
        end
    end

    assert_instant_protect_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_cmp |-> (conv_off && fet_force_on));

    assert_full_dwell_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_flag) |-> (run_q >= 32'(DWELL_CYCLES)));

    assert_hold_protect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_off && !rel) |=> (conv_off && fet_force_on && chg_inhibit));

    assert_below_rch_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        below_rch |=> (!fault_flag && !chg_inhibit));

    assert_hz_cd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hz_mode || chip_dis) |=> !fault_flag);

    assert_inhibit_cover_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault_flag |-> (chg_inhibit && conv_off));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_off |-> (!chg_inhibit && !fault_flag && !fet_force_on));

endmodule

bind bovp_monitor bovp_monitor_chk #(
    .DWELL_CYCLES (DWELL_CYCLES)
) u_bovp_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ovp_cmp      (ovp_cmp),
    .below_rch    (below_rch),
    .hz_mode      (hz_mode),
    .chip_dis     (chip_dis),
    .conv_off     (conv_off),
    .fet_force_on (fet_force_on),
    .chg_inhibit  (chg_inhibit),
    .fault_flag   (fault_flag)
);

// File: tb/test_bovp_monitor.sv
module test_bovp_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 8;
    localparam int NVEC       = 16;

    // [15] ovp [14] below_rch [13] hz [12] cd [11:4] edges, [2] conv_off [1] inhibit [0] fault
    localparam logic [15:0] VEC [0:NVEC-1] = '{
        {4'b0000, 8'd2,  4'b0000},  // 0  R9 idle
        {4'b1000, 8'd0,  4'b0100},  // 1  R1 same-cycle protect
        {4'b1000, 8'd7,  4'b0110},  // 2  R2 one short of window
        {4'b1000, 8'd1,  4'b0111},  // 3  R2 Nth sample latches
        {4'b0000, 8'd3,  4'b0111},  // 4  R4 latched after drop
        {4'b0100, 8'd1,  4'b0000},  // 5  R5 recharge release
        {4'b1000, 8'd5,  4'b0110},  // 6  R3 short run
        {4'b0000, 8'd2,  4'b0110},  // 7  R4 hold without fault
        {4'b1000, 8'd7,  4'b0110},  // 8  R3 restart, 7 < N
        {4'b1000, 8'd1,  4'b0111},  // 9  R3 full run latches
        {4'b1010, 8'd1,  4'b0100},  // 10 R6 hz release
        {4'b1010, 8'd10, 4'b0100},  // 11 R6 no latch in hz
        {4'b0000, 8'd1,  4'b0000},  // 12 R6 idle after hz
        {4'b1000, 8'd8,  4'b0111},  // 13 R10 fresh full window
        {4'b0001, 8'd1,  4'b0000},  // 14 R6 chip_dis release
        {4'b0000, 8'd1,  4'b0000}   // 15 R10 clean idle
    };

    logic clk = 1'b0;
    logic rst_n, ovp_cmp, below_rch, hz_mode, chip_dis;
    logic conv_off, fet_force_on, chg_inhibit, fault_flag;
    int   n_checks = 0;
    int   n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bovp_monitor #(.DWELL_CYCLES(N)) i_bovp_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .ovp_cmp      (ovp_cmp),
        .below_rch    (below_rch),
        .hz_mode      (hz_mode),
        .chip_dis     (chip_dis),
        .conv_off     (conv_off),
        .fet_force_on (fet_force_on),
        .chg_inhibit  (chg_inhibit),
        .fault_flag   (fault_flag)
    );

    task automatic expect3(input string req, input logic e_conv, input logic e_inh,
                           input logic e_flt);
        n_checks++;
        if (conv_off !== e_conv || fet_force_on !== e_conv ||
            chg_inhibit !== e_inh || fault_flag !== e_flt) begin
            n_fail++;
            $display("FAIL %s: got conv=%b fet=%b inh=%b flt=%b, expected conv=%b fet=%b inh=%b flt=%b",
                     req, conv_off, fet_force_on, chg_inhibit, fault_flag,
                     e_conv, e_conv, e_inh, e_flt);
        end
    endtask

    task automatic drive(input logic o, input logic b, input logic h, input logic c);
        ovp_cmp = o; below_rch = b; hz_mode = h; chip_dis = c;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout, expected completion");
        finish_run();
    end

    initial begin
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        #1;
        expect3("R9 in reset", 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][15], VEC[i][14], VEC[i][13], VEC[i][12]);
            if (VEC[i][11:4] == 8'd0) begin
                #1;
            end else begin
                repeat (int'(VEC[i][11:4])) @(posedge clk);
                @(negedge clk);
            end
            expect3($sformatf("vector %0d", i), VEC[i][2], VEC[i][1], VEC[i][0]);
        end

        // R7: a release at the Nth sample wins over latching (hz_mode).
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        repeat (N - 1) @(posedge clk);
        @(negedge clk);
        expect3("R7 before final sample", 1'b1, 1'b1, 1'b0);
        drive(1'b1, 1'b0, 1'b1, 1'b0);
        @(posedge clk);
        @(negedge clk);
        expect3("R7 hz at final sample", 1'b1, 1'b0, 1'b0);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        expect3("R7 idle after", 1'b0, 1'b0, 1'b0);

        // R7: the same with below_rch.
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        repeat (N - 1) @(posedge clk);
        @(negedge clk);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        expect3("R7 below_rch at final sample", 1'b1, 1'b0, 1'b0);

        // R5: recharge release while holding, comparator low.
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        expect3("R4 hold", 1'b1, 1'b1, 1'b0);
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        expect3("R5 release from hold", 1'b0, 1'b0, 1'b0);

        // R8: the inhibit rises one edge after the first high sample.
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        #1;
        expect3("R8 before edge", 1'b1, 1'b0, 1'b0);
        @(posedge clk);
        @(negedge clk);
        expect3("R8 after first edge", 1'b1, 1'b1, 1'b0);
        repeat (N) @(posedge clk);
        @(negedge clk);
        expect3("R8 fault latched", 1'b1, 1'b1, 1'b1);

        // R9: reset with a latched fault.
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        rst_n = 1'b0;
        #1;
        expect3("R9 async reset", 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        expect3("R9 after reset", 1'b0, 1'b0, 1'b0);

        finish_run();
    end

endmodule